// File: doc/BRIEF.md
# Shared-Bus 32-Bit Processor Datapath

This block holds the storage and arithmetic of a small processor built around a single 32-bit transfer bus. It contains a program counter, a memory address register, an instruction register, two ALU operand latches, a sixteen-word general register bank, a 256-word data memory, an offset sign-extender and a one-bit zero flag. An external sequencer runs it by raising strobes. A drive strobe puts one source on the shared bus. A load or write strobe captures the bus into one destination at the next rising clock edge.

A typical instruction fetch takes three cycles. In the first, the program counter goes to both the address register and operand A. In the second, memory goes to the instruction register. In the third, the ALU increment result goes back to the program counter. The block gives the sequencer the instruction's opcode and the zero flag so that it can pick the next step. A host data input, which is a bus source like any other, is used to load programs and operands.

Top module: `sbus_datapath`

## Requirements
- R1: At most one drive strobe (dr_pc, dr_alu, dr_reg, dr_mem, dr_off, dr_ext) is high in a cycle, and bus_out shows the shared bus. With no driver the bus reads 0.
- R2: On a rising edge with its load strobe high, each of PC, MAR, IR, A and B takes the bus value. With the strobe low it keeps its value.
- R3: With dr_alu high, the bus carries the ALU result chosen by alu_fn: 00 gives A+B, 01 gives A-B, 10 gives ~(A&B), 11 gives A+1, all modulo 2^32.
- R4: zero_flag is set to (bus == 0) on every edge where dr_alu is high. It holds its value on every other edge.
- R5: The register index comes from the IR: reg_sel 00 picks Rx = IR[27:24], 01 picks Ry = IR[23:20], 10 picks Rz = IR[3:0], and 11 also picks Rx. The same index is used by dr_reg (read) and wr_reg (write the bus value).
- R6: Register 0 always reads 0, and writes to it have no effect.
- R7: Memory is addressed by MAR[7:0] (upper MAR bits ignored). wr_mem stores the bus value on the edge, and dr_mem drives the addressed word in the same cycle.
- R8: dr_off drives IR[19:0] sign-extended to 32 bits.
- R9: opcode always equals IR[31:28].
- R10: After reset, PC, MAR, IR, A, B and zero_flag are all 0.
- R11: dr_ext places ext_data on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dr_pc | input | 1 | Drive program counter onto bus |
| dr_alu | input | 1 | Drive ALU result onto bus, update zero flag |
| dr_reg | input | 1 | Drive selected register onto bus |
| dr_mem | input | 1 | Drive memory word at MAR onto bus |
| dr_off | input | 1 | Drive sign-extended IR offset onto bus |
| dr_ext | input | 1 | Drive host data onto bus |
| ext_data | input | 32 | Host data for dr_ext |
| ld_pc | input | 1 | Load PC from bus |
| ld_a | input | 1 | Load operand A from bus |
| ld_b | input | 1 | Load operand B from bus |
| ld_mar | input | 1 | Load MAR from bus |
| ld_ir | input | 1 | Load IR from bus |
| wr_mem | input | 1 | Write bus into memory at MAR |
| wr_reg | input | 1 | Write bus into selected register |
| alu_fn | input | 2 | ALU function select |
| reg_sel | input | 2 | Register index select among IR fields |
| opcode | output | 4 | IR[31:28] |
| zero_flag | output | 1 | Zero flag register |
| bus_out | output | 32 | Current shared-bus value |

## Verification
The bench targets subtraction of equal operands. A design that takes the zero flag from the wrong value, or that also updates it on cycles without the ALU, leaves zero_flag wrong afterwards. The offset is tested at the 20-bit sign boundary, where zero-extension or the wrong sign bit gives 0x00080000 in place of 0xFFF80000. Register 0 is written and read back, which exposes a bank that stores it. Each IR field is used as an index, and a swapped field shows up as the wrong word read back. A MAR value above 255 must alias onto a low word. A full three-cycle fetch checks that the loaded opcode and the incremented PC come out right.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
    localparam int unsigned DW      = 32;
    localparam int unsigned OPC_W   = 4;
    localparam int unsigned RIDX_W  = 4;
    localparam int unsigned OFF_W   = 20;
    localparam int unsigned RX_LSB  = 24;
    localparam int unsigned RY_LSB  = 20;
    localparam int unsigned RZ_LSB  = 0;

    typedef enum logic [1:0] {
        FN_ADD  = 2'b00,
        FN_SUB  = 2'b01,
        FN_NAND = 2'b10,
        FN_INC  = 2'b11
    } alu_fn_e;

    typedef struct packed {
        logic [DW-1:0] pc;
        logic [DW-1:0] mar;
        logic [DW-1:0] ir;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic          z;
    } dp_state_t;
endpackage

// File: rtl/sbus_alu.sv
module sbus_alu #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   fn,
    output logic [W-1:0] y
);
    import sbus_pkg::*;

    always_comb begin
        unique case (alu_fn_e'(fn))
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_NAND: y = ~(a & b);
            FN_INC:  y = a + W'(1);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
    parameter int unsigned W = 32,
    parameter int unsigned N = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] idx,
    input  logic [W-1:0]         wdata,
    output logic [W-1:0]         rdata
);
    localparam int unsigned IW = $clog2(N);

    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we && idx != '0) begin
            regs_d[idx] = wdata;
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign rdata = (idx == IW'(0)) ? '0 : regs_q[idx];

    // R6: a write aimed at register 0 leaves register 0 at zero
    a_r6_r0_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == '0) |=> (regs_q[0] == '0));
endmodule

// File: rtl/sbus_mem.sv
module sbus_mem #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [W-1:0]             wdata,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

    // R7: a written word reads back on the next cycle if the address holds
    a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (we ##1 (addr == $past(addr))) |-> (rdata == $past(wdata)));
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
    parameter int unsigned REG_N     = 16,
    parameter int unsigned MEM_WORDS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dr_pc,
    input  logic        dr_alu,
    input  logic        dr_reg,
    input  logic        dr_mem,
    input  logic        dr_off,
    input  logic        dr_ext,
    input  logic [31:0] ext_data,
    input  logic        ld_pc,
    input  logic        ld_a,
    input  logic        ld_b,
    input  logic        ld_mar,
    input  logic        ld_ir,
    input  logic        wr_mem,
    input  logic        wr_reg,
    input  logic [1:0]  alu_fn,
    input  logic [1:0]  reg_sel,
    output logic [3:0]  opcode,
    output logic        zero_flag,
    output logic [31:0] bus_out
);
    import sbus_pkg::*;

    localparam int unsigned IW   = $clog2(REG_N);
    localparam int unsigned MAW  = $clog2(MEM_WORDS);
    localparam int unsigned NDRV = 6;

    dp_state_t st_d, st_q;

    logic [DW-1:0] bus;
    logic [DW-1:0] alu_y, reg_rd, mem_rd, off_ext;
    logic [IW-1:0] reg_idx;
    logic [NDRV-1:0] drv;

    // Operand index selection from instruction fields
    always_comb begin
        unique case (reg_sel)
            2'b01:   reg_idx = st_q.ir[RY_LSB +: IW];
            2'b10:   reg_idx = st_q.ir[RZ_LSB +: IW];
            default: reg_idx = st_q.ir[RX_LSB +: IW];
        endcase
    end

    assign off_ext = {{(DW-OFF_W){st_q.ir[OFF_W-1]}}, st_q.ir[OFF_W-1:0]};

    sbus_alu #(.W(DW)) u_alu (
        .a (st_q.a),
        .b (st_q.b),
        .fn(alu_fn),
        .y (alu_y)
    );

    sbus_regfile #(.W(DW), .N(REG_N)) u_rf (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_reg),
        .idx  (reg_idx),
        .wdata(bus),
        .rdata(reg_rd)
    );

    sbus_mem #(.W(DW), .DEPTH(MEM_WORDS)) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_mem),
        .addr (st_q.mar[MAW-1:0]),
        .wdata(bus),
        .rdata(mem_rd)
    );

    // Shared bus: AND-OR of gated sources, drivers are mutually exclusive
    assign drv = {dr_pc, dr_alu, dr_reg, dr_mem, dr_off, dr_ext};

    always_comb begin
        bus = ({DW{dr_pc}}  & st_q.pc)
            | ({DW{dr_alu}} & alu_y)
            | ({DW{dr_reg}} & reg_rd)
            | ({DW{dr_mem}} & mem_rd)
            | ({DW{dr_off}} & off_ext)
            | ({DW{dr_ext}} & ext_data);
    end

    always_comb begin
        st_d = st_q;
        if (ld_pc)  st_d.pc  = bus;
        if (ld_mar) st_d.mar = bus;
        if (ld_ir)  st_d.ir  = bus;
        if (ld_a)   st_d.a   = bus;
        if (ld_b)   st_d.b   = bus;
        if (dr_alu) st_d.z   = (bus == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign opcode    = st_q.ir[DW-1 -: OPC_W];
    assign zero_flag = st_q.z;
    assign bus_out   = bus;

    // R1: bus drivers never collide
    a_r1_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv));

    // R4: flag follows the bus value of an ALU cycle
    a_r4_z_capture: assert property (@(posedge clk) disable iff (!rst_n)
        dr_alu |=> (zero_flag == ($past(bus_out) == '0)));

    // R4: flag holds without an ALU drive
    a_r4_z_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dr_alu |=> $stable(zero_flag));

    // R2: PC captures the bus
    a_r2_pc_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pc |=> (st_q.pc == $past(bus_out)));

    // R9: opcode reflects the top bits of a loaded instruction
    a_r9_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ir |=> (opcode == $past(bus_out[31:28])));
endmodule

// File: tb/tb_sbus_datapath.sv
module tb_sbus_datapath;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dr_pc, dr_alu, dr_reg, dr_mem, dr_off, dr_ext;
    logic [31:0] ext_data;
    logic        ld_pc, ld_a, ld_b, ld_mar, ld_ir, wr_mem, wr_reg;
    logic [1:0]  alu_fn, reg_sel;
    logic [3:0]  opcode;
    logic        zero_flag;
    logic [31:0] bus_out;

    int n_chk  = 0;
    int n_fail = 0;

    localparam int S_PC  = 0;
    localparam int S_REG = 1;
    localparam int S_MEM = 2;
    localparam int S_OFF = 3;
    localparam int S_NONE = 4;

    always #2 clk = ~clk;

    sbus_datapath dut (
        .clk(clk), .rst_n(rst_n),
        .dr_pc(dr_pc), .dr_alu(dr_alu), .dr_reg(dr_reg), .dr_mem(dr_mem),
        .dr_off(dr_off), .dr_ext(dr_ext), .ext_data(ext_data),
        .ld_pc(ld_pc), .ld_a(ld_a), .ld_b(ld_b), .ld_mar(ld_mar), .ld_ir(ld_ir),
        .wr_mem(wr_mem), .wr_reg(wr_reg), .alu_fn(alu_fn), .reg_sel(reg_sel),
        .opcode(opcode), .zero_flag(zero_flag), .bus_out(bus_out)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clr();
        dr_pc = 0; dr_alu = 0; dr_reg = 0; dr_mem = 0; dr_off = 0; dr_ext = 0;
        ld_pc = 0; ld_a = 0; ld_b = 0; ld_mar = 0; ld_ir = 0;
        wr_mem = 0; wr_reg = 0; alu_fn = 2'b00; reg_sel = 2'b00; ext_data = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        clr();
    endtask

    // Drive host data and strobe the chosen destinations for one cycle
    task automatic ext_xfer(input logic [31:0] v, input bit lpc, input bit la,
                            input bit lb, input bit lmar, input bit lir,
                            input bit wm, input bit wr, input logic [1:0] sel);
        dr_ext = 1; ext_data = v;
        ld_pc = lpc; ld_a = la; ld_b = lb; ld_mar = lmar; ld_ir = lir;
        wr_mem = wm; wr_reg = wr; reg_sel = sel;
        tick();
    endtask

    // Put one source on the bus without loading anything and read it
    task automatic look(input int src, input logic [1:0] sel, output logic [31:0] v);
        reg_sel = sel;
        case (src)
            S_PC:  dr_pc  = 1;
            S_REG: dr_reg = 1;
            S_MEM: dr_mem = 1;
            S_OFF: dr_off = 1;
            default: ;
        endcase
        #1;
        v = bus_out;
        clr();
        #0.5;
    endtask

    task automatic mem_write(input logic [31:0] addr, input logic [31:0] data);
        ext_xfer(addr, 0, 0, 0, 1, 0, 0, 0, 2'b00);
        ext_xfer(data, 0, 0, 0, 0, 0, 1, 0, 2'b00);
    endtask

    task automatic alu_op(input logic [1:0] fn, input logic [31:0] exp,
                          input logic exp_z, input string what);
        alu_fn = fn; dr_alu = 1;
        #1;
        chk(bus_out, exp, "R3", what);
        tick();
        chk({31'b0, zero_flag}, {31'b0, exp_z}, "R4", {what, " zero flag"});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        look(S_PC, 2'b00, v);
        chk(v, 32'h0, "R10", "PC after reset");
        chk({28'b0, opcode}, 32'h0, "R10", "opcode after reset");
        chk({31'b0, zero_flag}, 32'h0, "R10", "zero flag after reset");
        look(S_OFF, 2'b00, v);
        chk(v, 32'h0, "R10", "IR offset after reset");
        look(S_NONE, 2'b00, v);
        chk(v, 32'h0, "R1", "idle bus");
    endtask

    task automatic t_loads();
        logic [31:0] v;
        dr_ext = 1; ext_data = 32'h5A5A_0F0F;
        #1;
        chk(bus_out, 32'h5A5A_0F0F, "R11", "host data on bus");
        clr();
        ext_xfer(32'h1234_5678, 1, 0, 0, 0, 0, 0, 0, 2'b00);
        look(S_PC, 2'b00, v);
        chk(v, 32'h1234_5678, "R2", "PC loaded");
        ext_xfer(32'h0BAD_0BAD, 0, 0, 0, 0, 0, 0, 0, 2'b00);
        look(S_PC, 2'b00, v);
        chk(v, 32'h1234_5678, "R2", "PC held without strobe");
        ext_xfer(32'hA000_0000, 0, 0, 0, 0, 1, 0, 0, 2'b00);
        chk({28'b0, opcode}, 32'hA, "R9", "opcode from IR");
    endtask

    task automatic t_alu();
        ext_xfer(32'd5, 0, 1, 0, 0, 0, 0, 0, 2'b00);
        ext_xfer(32'd3, 0, 0, 1, 0, 0, 0, 0, 2'b00);
        alu_op(2'b00, 32'd8, 1'b0, "add");
        alu_op(2'b01, 32'd2, 1'b0, "sub");
        alu_op(2'b10, 32'hFFFF_FFFE, 1'b0, "nand");
        alu_op(2'b11, 32'd6, 1'b0, "inc");
        ext_xfer(32'd7, 0, 1, 1, 0, 0, 0, 0, 2'b00);
        alu_op(2'b01, 32'd0, 1'b1, "sub equal");
        ext_xfer(32'd0, 0, 0, 0, 0, 0, 0, 0, 2'b00);
        chk({31'b0, zero_flag}, 32'h1, "R4", "flag held on non-ALU zero bus");
        ext_xfer(32'd9, 0, 0, 0, 0, 0, 0, 0, 2'b00);
        chk({31'b0, zero_flag}, 32'h1, "R4", "flag held on non-ALU nonzero bus");
        alu_op(2'b00, 32'd14, 1'b0, "add clears flag");
        ext_xfer(32'hFFFF_FFFF, 0, 1, 0, 0, 0, 0, 0, 2'b00);
        alu_op(2'b11, 32'd0, 1'b1, "inc wraps");
    endtask

    task automatic t_regs();
        logic [31:0] v;
        // Rx=3, Ry=5, Rz=9
        ext_xfer(32'h0350_0009, 0, 0, 0, 0, 1, 0, 0, 2'b00);
        ext_xfer(32'h0000_0111, 0, 0, 0, 0, 0, 0, 1, 2'b00);
        ext_xfer(32'h0000_0555, 0, 0, 0, 0, 0, 0, 1, 2'b01);
        ext_xfer(32'h0000_0999, 0, 0, 0, 0, 0, 0, 1, 2'b10);
        look(S_REG, 2'b00, v); chk(v, 32'h111, "R5", "read via Rx");
        look(S_REG, 2'b01, v); chk(v, 32'h555, "R5", "read via Ry");
        look(S_REG, 2'b10, v); chk(v, 32'h999, "R5", "read via Rz");
        look(S_REG, 2'b11, v); chk(v, 32'h111, "R5", "select 11 uses Rx");
        // Rx=0
        ext_xfer(32'h0000_0000, 0, 0, 0, 0, 1, 0, 0, 2'b00);
        ext_xfer(32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, 1, 2'b00);
        look(S_REG, 2'b00, v); chk(v, 32'h0, "R6", "register 0 ignores write");
    endtask

    task automatic t_mem();
        logic [31:0] v;
        mem_write(32'h10, 32'hCAFE_F00D);
        mem_write(32'h11, 32'h0000_0001);
        ext_xfer(32'h10, 0, 0, 0, 1, 0, 0, 0, 2'b00);
        look(S_MEM, 2'b00, v); chk(v, 32'hCAFE_F00D, "R7", "read word 0x10");
        ext_xfer(32'h11, 0, 0, 0, 1, 0, 0, 0, 2'b00);
        look(S_MEM, 2'b00, v); chk(v, 32'h1, "R7", "read word 0x11");
        ext_xfer(32'h110, 0, 0, 0, 1, 0, 0, 0, 2'b00);
        look(S_MEM, 2'b00, v); chk(v, 32'hCAFE_F00D, "R7", "high MAR bits ignored");
    endtask

    task automatic t_off();
        logic [31:0] v;
        ext_xfer(32'h0008_0000, 0, 0, 0, 0, 1, 0, 0, 2'b00);
        look(S_OFF, 2'b00, v); chk(v, 32'hFFF8_0000, "R8", "negative offset");
        ext_xfer(32'hF007_FFFF, 0, 0, 0, 0, 1, 0, 0, 2'b00);
        look(S_OFF, 2'b00, v); chk(v, 32'h0007_FFFF, "R8", "largest positive offset");
    endtask

    task automatic t_fetch();
        logic [31:0] v;
        mem_write(32'h0, 32'h7350_0009);
        ext_xfer(32'h0, 1, 0, 0, 0, 0, 0, 0, 2'b00);
        dr_pc = 1; ld_mar = 1; ld_a = 1;
        tick();
        dr_mem = 1; ld_ir = 1;
        #1;
        chk(bus_out, 32'h7350_0009, "R7", "fetch memory read");
        tick();
        chk({28'b0, opcode}, 32'h7, "R9", "fetched opcode");
        alu_fn = 2'b11; dr_alu = 1; ld_pc = 1;
        tick();
        look(S_PC, 2'b00, v);
        chk(v, 32'h1, "R2", "PC incremented by fetch");
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog R1-timeout: actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        clr();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_loads();
        t_alu();
        t_regs();
        t_mem();
        t_off();
        t_fetch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule